// File: doc/BRIEF.md
# Multipumped Multi-Port RAM

This block is a word-addressed memory with several independent write ports and several independent read ports. It is built from a small number of true dual-port synchronous storage arrays. These arrays run on a fast internal clock whose frequency is a fixed integer multiple (the pumping factor) of the external port clock. Both clocks come from outside the block, are synchronous and have their rising edges aligned. All requests presented in one port-clock cycle are captured together. They are then served across the fast phases of that cycle, one slot after another.

The read ports are spread over the arrays: each array serves two read ports through its two physical ports in a single read slot. Every write is copied into every array, so each array always holds the full contents and no word is ever split across arrays. The schedule inside each port cycle is fixed. The first fast slot after capture is the read slot. The following slots are write slots, each serving two write ports in ascending port order. A read therefore always sees memory as it stood before the writes of its own cycle.

The block is used where a register file, shared table or queue storage needs more ports than a block RAM offers, and a lower port frequency is acceptable. The pumping factor must be at least one plus half the number of write ports, rounded up. The reset must be released just after a rising edge of the port clock.

Top module: `mpram_pump`

## Requirements
- R1: While `rst` is high at a port-clock edge, every read data output is zero after that edge.
- R2: The read address captured at one port-clock edge gives its data on that port's output after the next port-clock edge. The output does not change between port-clock edges.
- R3: A read whose address matches a write captured at the same port edge returns the word as it stood before that write.
- R4: A word written on any write port is returned by every read port that reads that address in any later port cycle.
- R5: When several write ports with the enable high target the same address in one port cycle, the highest-numbered such port determines the stored word.
- R6: A write port whose enable is low changes no word, whatever its address and data inputs hold.
- R7: All read ports are served in the same port cycle, with independent addresses. This includes several ports reading the same address.
- R8: The lowest address (0) and the highest address (DEPTH-1) are each stored and read back like any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_port | input | 1 | External port clock, rising edges aligned with `clk_fast` |
| clk_fast | input | 1 | Internal array clock, PUMP times the port clock frequency |
| rst | input | 1 | Synchronous active-high reset, released just after a port-clock rising edge |
| wr_en | input | NW | Write enable per write port, bit i for port i |
| wr_addr | input | NW x AW | Write address per write port |
| wr_data | input | NW x DW | Write data per write port |
| rd_addr | input | NR x AW | Read address per read port |
| rd_data | output | NR x DW | Registered read data per read port |

## Verification
The assertions assume that both clocks keep a fixed phase relation, with a port-clock rising edge on every PUMP-th fast edge. They also assume that the reset falls between the port edge and the next fast edge, so the fast sequencer begins in the read slot. The bench builds both clocks from one half-period constant and drives every input two time units after a port edge, far from any fast edge. It releases the reset in the same way. Random addresses are drawn from a narrow range, so that same-address writes and reads of just-written words occur often.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  // Kind of work the arrays perform on the coming fast edge.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_READ  = 2'd1,
    SLOT_WRITE = 2'd2
  } slot_e;

  // Number of pairs needed to cover n ports with two physical ports each.
  function automatic int pair_count(input int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/mpr_req_capture.sv
// Port-clock capture of every request of one external cycle.
module mpr_req_capture #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int NW = 2,
  parameter int NR = 4
) (
  input  logic                   clk_port,
  input  logic                   rst,
  input  logic [NW-1:0]          wr_en,
  input  logic [NW-1:0][AW-1:0]  wr_addr,
  input  logic [NW-1:0][DW-1:0]  wr_data,
  input  logic [NR-1:0][AW-1:0]  rd_addr,
  output logic [NW-1:0]          cap_en,
  output logic [NW-1:0][AW-1:0]  cap_waddr,
  output logic [NW-1:0][DW-1:0]  cap_wdata,
  output logic [NR-1:0][AW-1:0]  cap_raddr
);

  always_ff @(posedge clk_port) begin
    if (rst) begin
      cap_en    <= '0;
      cap_waddr <= '0;
      cap_wdata <= '0;
      cap_raddr <= '0;
    end else begin
      cap_en    <= wr_en;
      cap_waddr <= wr_addr;
      cap_wdata <= wr_data;
      cap_raddr <= rd_addr;
    end
  end

endmodule

// File: rtl/mpr_phase_seq.sv
// Fast-clock slot sequencer. The register holds the index of the coming
// fast edge inside the port cycle: 0 is the edge aligned with the port
// clock, 1 is the read slot, and 2..PUMP-1 then 0 are write slots in order.
module mpr_phase_seq import mpr_pkg::*; #(
  parameter  int NW   = 2,
  parameter  int PUMP = 2,
  localparam int PW   = $clog2(PUMP),
  localparam int WPH  = (NW + 1) / 2
) (
  input  logic          clk_fast,
  input  logic          rst,
  output slot_e         slot_kind,
  output logic [PW-1:0] wslot,
  output logic          snap
);

  logic [PW-1:0] ph;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      ph <= PW'(1);
    end else if (ph == PW'(PUMP - 1)) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  always_comb begin
    if (ph == '0) begin
      wslot = PW'(PUMP - 2);
    end else begin
      wslot = ph - PW'(2);
    end

    if (ph == PW'(1)) begin
      slot_kind = SLOT_READ;
    end else if (int'(wslot) < WPH) begin
      slot_kind = SLOT_WRITE;
    end else begin
      slot_kind = SLOT_IDLE;
    end
  end

  assign snap = (ph == PW'(1));

endmodule

// File: rtl/mpr_wr_sched.sv
// Holds the write requests of the current port cycle in the fast domain
// and hands out one pair of writes per write slot, lower port on side a.
module mpr_wr_sched import mpr_pkg::*; #(
  parameter  int DW  = 16,
  parameter  int AW  = 5,
  parameter  int NW  = 2,
  parameter  int PW  = 1,
  localparam int WPH = (NW + 1) / 2,
  localparam int NWP = 2 * WPH
) (
  input  logic                  clk_fast,
  input  logic                  rst,
  input  logic                  snap,
  input  slot_e                 slot_kind,
  input  logic [PW-1:0]         wslot,
  input  logic [NW-1:0]         cap_en,
  input  logic [NW-1:0][AW-1:0] cap_waddr,
  input  logic [NW-1:0][DW-1:0] cap_wdata,
  output logic                  wa_en,
  output logic [AW-1:0]         wa_addr,
  output logic [DW-1:0]         wa_data,
  output logic                  wb_en,
  output logic [AW-1:0]         wb_addr,
  output logic [DW-1:0]         wb_data
);

  logic          sh_en   [NWP];
  logic [AW-1:0] sh_addr [NWP];
  logic [DW-1:0] sh_data [NWP];

  // Shadow copy taken in the read slot, while the capture registers are
  // stable, so later write slots never sample them at a port edge.
  for (genvar i = 0; i < NWP; i++) begin : g_sh
    if (i < NW) begin : g_live
      always_ff @(posedge clk_fast) begin
        if (rst) begin
          sh_en[i]   <= 1'b0;
          sh_addr[i] <= '0;
          sh_data[i] <= '0;
        end else if (snap) begin
          sh_en[i]   <= cap_en[i];
          sh_addr[i] <= cap_waddr[i];
          sh_data[i] <= cap_wdata[i];
        end
      end
    end else begin : g_pad
      assign sh_en[i]   = 1'b0;
      assign sh_addr[i] = '0;
      assign sh_data[i] = '0;
    end
  end

  logic          pa_en, pb_en;
  logic [AW-1:0] pa_addr, pb_addr;
  logic [DW-1:0] pa_data, pb_data;

  always_comb begin
    pa_en   = 1'b0;
    pa_addr = '0;
    pa_data = '0;
    pb_en   = 1'b0;
    pb_addr = '0;
    pb_data = '0;
    for (int k = 0; k < WPH; k++) begin
      if (int'(wslot) == k) begin
        pa_en   = sh_en[2*k];
        pa_addr = sh_addr[2*k];
        pa_data = sh_data[2*k];
        pb_en   = sh_en[2*k+1];
        pb_addr = sh_addr[2*k+1];
        pb_data = sh_data[2*k+1];
      end
    end
  end

  logic active;
  assign active = (slot_kind == SLOT_WRITE) && !rst;

  // Side b carries the higher port; on a shared address side a stands down.
  assign wb_en   = active && pb_en;
  assign wa_en   = active && pa_en && !(pb_en && (pa_addr == pb_addr));
  assign wa_addr = pa_addr;
  assign wa_data = pa_data;
  assign wb_addr = pb_addr;
  assign wb_data = pb_data;

endmodule

// File: rtl/mpr_tdp_ram.sv
// One storage array: two read/write ports on one clock, read data held
// unless a read is requested.
module mpr_tdp_ram #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] din_a,
  output logic [DW-1:0] q_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] q_b
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) begin
      mem[addr_a] <= din_a;
    end
    if (we_b) begin
      mem[addr_b] <= din_b;
    end
    if (re) begin
      q_a <= mem[addr_a];
      q_b <= mem[addr_b];
    end
  end

endmodule

// File: rtl/mpr_rd_out.sv
// Port-clock output registers for all read ports.
module mpr_rd_out #(
  parameter int DW = 16,
  parameter int NR = 4
) (
  input  logic                  clk_port,
  input  logic                  rst,
  input  logic [NR-1:0][DW-1:0] rq,
  output logic [NR-1:0][DW-1:0] rd_data
);

  always_ff @(posedge clk_port) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rq;
    end
  end

endmodule

// File: rtl/mpram_pump.sv
module mpram_pump import mpr_pkg::*; #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 32,
  parameter  int NW    = 2,
  parameter  int NR    = 4,
  parameter  int PUMP  = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                  clk_port,
  input  logic                  clk_fast,
  input  logic                  rst,
  input  logic [NW-1:0]         wr_en,
  input  logic [NW-1:0][AW-1:0] wr_addr,
  input  logic [NW-1:0][DW-1:0] wr_data,
  input  logic [NR-1:0][AW-1:0] rd_addr,
  output logic [NR-1:0][DW-1:0] rd_data
);

  localparam int PW    = $clog2(PUMP);
  localparam int NCOPY = pair_count(NR);

  logic [NW-1:0]         cap_en;
  logic [NW-1:0][AW-1:0] cap_waddr;
  logic [NW-1:0][DW-1:0] cap_wdata;
  logic [NR-1:0][AW-1:0] cap_raddr;

  mpr_req_capture #(.DW(DW), .AW(AW), .NW(NW), .NR(NR)) u_cap (
    .clk_port (clk_port),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .cap_en   (cap_en),
    .cap_waddr(cap_waddr),
    .cap_wdata(cap_wdata),
    .cap_raddr(cap_raddr)
  );

  slot_e         slot_kind;
  logic [PW-1:0] wslot;
  logic          snap;

  mpr_phase_seq #(.NW(NW), .PUMP(PUMP)) u_seq (
    .clk_fast (clk_fast),
    .rst      (rst),
    .slot_kind(slot_kind),
    .wslot    (wslot),
    .snap     (snap)
  );

  logic          wa_en, wb_en;
  logic [AW-1:0] wa_addr, wb_addr;
  logic [DW-1:0] wa_data, wb_data;

  mpr_wr_sched #(.DW(DW), .AW(AW), .NW(NW), .PW(PW)) u_sched (
    .clk_fast (clk_fast),
    .rst      (rst),
    .snap     (snap),
    .slot_kind(slot_kind),
    .wslot    (wslot),
    .cap_en   (cap_en),
    .cap_waddr(cap_waddr),
    .cap_wdata(cap_wdata),
    .wa_en    (wa_en),
    .wa_addr  (wa_addr),
    .wa_data  (wa_data),
    .wb_en    (wb_en),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data)
  );

  logic rd_slot;
  assign rd_slot = (slot_kind == SLOT_READ);

  logic [NCOPY-1:0][DW-1:0] qa;
  logic [NCOPY-1:0][DW-1:0] qb;

  // Each array serves read ports 2c and 2c+1 in the read slot and repeats
  // the same write pair as all other arrays in the write slots.
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    logic [AW-1:0] ra, rb;
    assign ra = cap_raddr[2*c];
    if (2*c + 1 < NR) begin : g_pair
      assign rb = cap_raddr[2*c+1];
    end else begin : g_single
      assign rb = '0;
    end

    mpr_tdp_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk   (clk_fast),
      .re    (rd_slot),
      .we_a  (wa_en),
      .addr_a(rd_slot ? ra : wa_addr),
      .din_a (wa_data),
      .q_a   (qa[c]),
      .we_b  (wb_en),
      .addr_b(rd_slot ? rb : wb_addr),
      .din_b (wb_data),
      .q_b   (qb[c])
    );
  end

  logic [NR-1:0][DW-1:0] rq;

  for (genvar r = 0; r < NR; r++) begin : g_steer
    if (r % 2 == 0) begin : g_side_a
      assign rq[r] = qa[r/2];
    end else begin : g_side_b
      assign rq[r] = qb[r/2];
    end
  end

  mpr_rd_out #(.DW(DW), .NR(NR)) u_out (
    .clk_port(clk_port),
    .rst     (rst),
    .rq      (rq),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/mpr_pump_chk.sv
module mpr_pump_chk import mpr_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int NR = 4
) (
  input logic                  clk_port,
  input logic                  clk_fast,
  input logic                  rst,
  input slot_e                 slot_kind,
  input logic                  wa_en,
  input logic                  wb_en,
  input logic [AW-1:0]         wa_addr,
  input logic [AW-1:0]         wb_addr,
  input logic [NR-1:0][AW-1:0] cap_raddr,
  input logic [NR-1:0][DW-1:0] rq,
  input logic [NR-1:0][DW-1:0] rd_data
);

  // R1: the first port edge after reset still shows cleared outputs.
  p_reset_clear_r1: assert property (@(posedge clk_port) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  // R2: outputs move only with the port clock, seen at the read slot edge.
  p_out_steady_r2: assert property (@(posedge clk_fast) disable iff (rst)
    (slot_kind != SLOT_READ) |-> $stable(rd_data));

  // R3: the read slot carries no write, so reads see pre-cycle contents.
  p_read_slot_clean_r3: assert property (@(posedge clk_fast) disable iff (rst)
    (slot_kind == SLOT_READ) |-> !(wa_en || wb_en));

  // R5: the two physical sides never write one word on the same edge.
  p_pair_distinct_r5: assert property (@(posedge clk_fast) disable iff (rst)
    (wa_en && wb_en) |-> (wa_addr != wb_addr));

  // R4: two arrays asked for the same word return the same bits.
  if (NR > 2) begin : g_copy_cmp
    p_copies_agree_r4: assert property (@(posedge clk_port) disable iff (rst)
      (cap_raddr[0] == cap_raddr[2]) |-> (rq[0] === rq[2]));
  end

endmodule

bind mpram_pump mpr_pump_chk #(.DW(DW), .AW(AW), .NR(NR)) u_chk (
  .clk_port (clk_port),
  .clk_fast (clk_fast),
  .rst      (rst),
  .slot_kind(slot_kind),
  .wa_en    (wa_en),
  .wb_en    (wb_en),
  .wa_addr  (wa_addr),
  .wb_addr  (wb_addr),
  .cap_raddr(cap_raddr),
  .rq       (rq),
  .rd_data  (rd_data)
);

// File: tb/mpram_pump_tb.sv
module mpram_pump_tb;

  localparam int DW    = 16;
  localparam int DEPTH = 32;
  localparam int NW    = 2;
  localparam int NR    = 4;
  localparam int PUMP  = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CLK_PERIOD = 10;           // fast clock period
  localparam int HALF       = CLK_PERIOD / 2;

  logic clk_fast = 1'b0;
  logic clk_port = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]         wr_en   = '0;
  logic [NW-1:0][AW-1:0] wr_addr = '0;
  logic [NW-1:0][DW-1:0] wr_data = '0;
  logic [NR-1:0][AW-1:0] rd_addr = '0;
  logic [NR-1:0][DW-1:0] rd_data;

  mpram_pump #(.DW(DW), .DEPTH(DEPTH), .NW(NW), .NR(NR), .PUMP(PUMP)) u_dut (
    .clk_port(clk_port),
    .clk_fast(clk_fast),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  initial forever #(HALF) clk_fast = ~clk_fast;
  initial begin
    #(HALF);
    forever begin
      clk_port = ~clk_port;
      #(HALF * PUMP);
    end
  end

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] pend_exp [NR];
  bit            pend_ok  [NR];
  bit            pend_v = 1'b0;
  string         pend_tag;

  function automatic logic [DW-1:0] seed_word(input int i);
    return DW'(i * 16'h1357) ^ DW'(16'hA5A5);
  endfunction

  task automatic check(input bit ok, input string tag, input int port,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s read port %0d actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  // One port cycle: inputs already driven are captured at the edge; the
  // previous cycle's reads are checked, then the model advances.
  task automatic step(input string tag);
    @(posedge clk_port);
    #2;
    if (pend_v) begin
      for (int r = 0; r < NR; r++) begin
        if (pend_ok[r]) check(rd_data[r] === pend_exp[r], pend_tag, r, rd_data[r], pend_exp[r]);
      end
    end
    for (int r = 0; r < NR; r++) begin
      pend_exp[r] = model[rd_addr[r]];
      pend_ok[r]  = known[rd_addr[r]];
    end
    pend_v   = 1'b1;
    pend_tag = tag;
    for (int w = 0; w < NW; w++) begin
      if (wr_en[w]) begin
        model[wr_addr[w]] = wr_data[w];
        known[wr_addr[w]] = 1'b1;
      end
    end
  endtask

  task automatic idle_inputs();
    wr_en   = '0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

    // R1: outputs cleared while reset is held
    repeat (3) @(posedge clk_port);
    #2;
    for (int r = 0; r < NR; r++) check(rd_data[r] == '0, "R1", r, rd_data[r], '0);
    @(posedge clk_port);
    #1 rst = 1'b0;
    #1;

    // fill every word, ports in parallel
    for (int base = 0; base < DEPTH; base += NW) begin
      idle_inputs();
      for (int w = 0; w < NW; w++) begin
        if (base + w < DEPTH) begin
          wr_en[w]   = 1'b1;
          wr_addr[w] = AW'(base + w);
          wr_data[w] = seed_word(base + w);
        end
      end
      step("fill");
    end

    // R8: both ends of the address range; R7: ports in parallel
    idle_inputs();
    for (int r = 0; r < NR; r++) rd_addr[r] = (r % 2 == 0) ? AW'(0) : AW'(DEPTH - 1);
    step("R8");

    // R3: read of a word written in the same cycle returns the old word
    idle_inputs();
    wr_en[0] = 1'b1; wr_addr[0] = AW'(5); wr_data[0] = DW'(16'hBEEF);
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(5);
    step("R3");

    // R4: the new word is seen on every read port
    idle_inputs();
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(5);
    step("R4");

    // R5: two writes to one word, highest port wins
    idle_inputs();
    wr_en = '1;
    wr_addr[0] = AW'(9); wr_data[0] = DW'(16'h1111);
    wr_addr[1] = AW'(9); wr_data[1] = DW'(16'h2222);
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(DEPTH - 1);
    step("R7");
    idle_inputs();
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(9);
    step("R5");

    // R6: disabled ports leave the word alone
    idle_inputs();
    wr_addr[0] = AW'(9); wr_data[0] = DW'(16'hDEAD);
    wr_addr[1] = AW'(9); wr_data[1] = DW'(16'hF00D);
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(9);
    step("R6 setup");
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(9);
    step("R6");

    // R2 R7: random mix over a narrow address window
    for (int n = 0; n < 400; n++) begin
      for (int w = 0; w < NW; w++) begin
        wr_en[w]   = 1'($urandom_range(0, 1));
        wr_addr[w] = AW'($urandom_range(0, 7));
        wr_data[w] = DW'($urandom);
      end
      for (int r = 0; r < NR; r++) rd_addr[r] = AW'($urandom_range(0, 7));
      step("R2 R7 random");
    end

    idle_inputs();
    step("flush");
    step("flush");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule